// File: doc/BRIEF.md
# Factorial Sequence Generator

A clocked datapath that walks through the factorials of 1 to a fixed upper index (7 by default) and presents each result as an index and value pair. An internal counter supplies the multiplier, a product register holds the running product, and a small controller decides when a step takes place and when the sequence has finished.

A synchronous `start_i` pulse or level loads the index with 1 and the product with 1. The outputs then show the pair (0, 1), which reads as 0! = 1. After `start_i` is released, every cycle with `enable_i` high takes one step: the product is multiplied by the current index and the pair is published with a one-cycle `valid_o` strobe. After the pair for the last index, `done_o` rises and stays high. The block then takes no further steps until `start_i` is asserted again. The product width comes from the upper index, so the largest result always fits.

Top module: `fact_seq`

## Requirements
- R1: After the asynchronous active-low reset `rst_ni`, `idx_o` is 0, `prod_o` is 1, `valid_o` is 0 and `done_o` is 0. No step occurs until `start_i` has been asserted, whatever `enable_i` does.
- R2: In every cycle after an edge at which `start_i` was high, `idx_o` is 0, `prod_o` is 1, `valid_o` is 0 and `done_o` is 0, whatever `enable_i` does.
- R3: Each step happens at an edge where `enable_i` is high, `start_i` is low and the sequence has not finished. After the step, `idx_o` equals the previous `idx_o` plus 1, `prod_o` equals the previous `prod_o` times the new `idx_o`, and `valid_o` is 1 for exactly that cycle.
- R4: An edge with `enable_i` low and `start_i` low leaves `idx_o`, `prod_o` and `done_o` unchanged and drives `valid_o` to 0 for the following cycle.
- R5: `done_o` rises in the same cycle as the pair for the upper index (7). It stays high, with no further `valid_o` pulse, until `start_i` is asserted.
- R6: Asserting `start_i` in the middle of a sequence or after `done_o` restarts the sequence from index 1.
- R7: With the default upper index of 7, the published values are 1, 2, 6, 24, 120, 720 and 5040 for indices 1 to 7. `prod_o` is 13 bits wide and `idx_o` is 3 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart of the sequence |
| enable_i | input | 1 | Allows one step per cycle when high |
| idx_o | output | 3 | Index of the published pair |
| prod_o | output | 13 | Factorial of `idx_o` |
| valid_o | output | 1 | One-cycle strobe marking a new pair |
| done_o | output | 1 | High from the last pair until the next start |

## Verification
An internal fault, such as a counter that skips a value, a product register that misses a load, or a controller stuck in the wrong state, shows up at the ports in the very next cycle. It appears as a pair whose value is not the factorial of its index, a `valid_o` strobe where none belongs, or a `done_o` that is early, late or drops out. The bench keeps its own model of index, product and finish state, driven only by `start_i` and `enable_i`, and compares every port every cycle. Its input patterns are continuous enable, sparse and periodic enable, restarts in the middle of a sequence and a `start_i` held for several cycles.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } fsg_state_e;

  function automatic int unsigned fact_of(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned k = 2; k <= n; k++) r = r * k;
    return r;
  endfunction
endpackage

// File: rtl/fsg_mul.sv
// Shift-add multiplier, result truncated to the product width.
module fsg_mul #(
  parameter int unsigned A_W = 13,
  parameter int unsigned B_W = 3
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [A_W-1:0] p_o
);
  logic [A_W-1:0] part [B_W];
  logic [A_W-1:0] acc  [B_W+1];

  assign acc[0] = '0;
  for (genvar i = 0; i < B_W; i++) begin : g_pp
    assign part[i]  = b_i[i] ? (a_i << i) : '0;
    assign acc[i+1] = acc[i] + part[i];
  end
  assign p_o = acc[B_W];
endmodule

// File: rtl/fsg_index.sv
module fsg_index #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned LIMIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] cnt_o,
  output logic             last_o
);
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= IDX_W'(1);
    else if (load_i) cnt_q <= IDX_W'(1);
    else if (step_i) cnt_q <= cnt_q + IDX_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == IDX_W'(LIMIT));

  // R3: the counter never steps past the upper index
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q >= IDX_W'(1)) && (cnt_q <= IDX_W'(LIMIT)));
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic enable_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic done_o
);
  fsg_state_e state_q, state_d;

  assign load_o = start_i;
  assign step_o = !start_i && enable_i && (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    if (start_i)                state_d = ST_RUN;
    else if (step_o && last_i)  state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign done_o = (state_q == ST_DONE);

  // R5: finished state is left only through a start
  a_r5_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R2: a start always leaves the controller running, not finished
  a_r2_start_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/fact_seq.sv
module fact_seq
  import fsg_pkg::*;
#(
  parameter int unsigned LIMIT = 7,
  localparam int unsigned IDX_W  = $clog2(LIMIT + 1),
  localparam int unsigned PROD_W = $clog2(fact_of(LIMIT) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PROD_W-1:0] prod_o,
  output logic              valid_o,
  output logic              done_o
);
  logic             load, step, last;
  logic [IDX_W-1:0] cnt;
  logic [PROD_W-1:0] prod_q, mul_res;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;

  fsg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .enable_i(enable_i),
    .last_i  (last),
    .load_o  (load),
    .step_o  (step),
    .done_o  (done_o)
  );

  fsg_index #(.IDX_W(IDX_W), .LIMIT(LIMIT)) u_index (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .cnt_o (cnt),
    .last_o(last)
  );

  fsg_mul #(.A_W(PROD_W), .B_W(IDX_W)) u_mul (
    .a_i(prod_q),
    .b_i(cnt),
    .p_o(mul_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= PROD_W'(1);
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step;
      if (load) begin
        prod_q <= PROD_W'(1);
        idx_q  <= '0;
      end else if (step) begin
        prod_q <= mul_res;
        idx_q  <= cnt;
      end
    end
  end

  assign idx_o   = idx_q;
  assign prod_o  = prod_q;
  assign valid_o = valid_q;

  // R3: a published pair is one index on, product scaled by that index
  a_r3_idx_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> idx_o == $past(idx_o) + IDX_W'(1));
  a_r3_prod_mul: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> prod_o == PROD_W'($past(prod_o) * $past(idx_o + IDX_W'(1))));
  // R4: a disabled cycle holds the pair and suppresses the strobe
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !start_i) |=> !valid_o && $stable(prod_o) && $stable(idx_o));
  // R2: start clears the pair
  a_r2_start_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_o == '0) && (prod_o == PROD_W'(1)) && !valid_o);
  // R5: no strobe once finished
  a_r5_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !valid_o);
endmodule

// File: tb/tb_fact_seq.sv
module tb_fact_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  idx;
  logic [12:0] prod;
  logic        valid, done;

  int ntests = 0;
  int nfail  = 0;

  // bench model
  int  m_idx = 0;
  int  m_prod = 1;
  bit  m_valid = 0, m_done = 0, m_run = 0;

  always #4 clk = ~clk;

  fact_seq dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .enable_i(en),
    .idx_o   (idx),
    .prod_o  (prod),
    .valid_o (valid),
    .done_o  (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fact(input int n);
    int r = 1;
    for (int k = 2; k <= n; k++) r *= k;
    return r;
  endfunction

  task automatic compare(input string req);
    chk(idx == m_idx[2:0], {req, " idx"}, idx, m_idx);
    chk(prod == m_prod[12:0], {req, " prod"}, prod, m_prod);
    chk(valid == m_valid, {req, " valid"}, valid, m_valid);
    chk(done == m_done, {req, " done"}, done, m_done);
  endtask

  // apply inputs at negedge, advance model, check at next negedge
  task automatic cycle(input bit s, input bit e, input string req);
    start = s;
    en = e;
    if (s) begin
      m_idx = 0; m_prod = 1; m_valid = 0; m_done = 0; m_run = 1;
    end else if (e && m_run && !m_done) begin
      m_idx++;
      m_prod = m_prod * m_idx;
      m_valid = 1;
      if (m_idx == 7) m_done = 1;
    end else begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #400000;
    nfail++;
    ntests++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset");
    // R1: enable without start does nothing
    for (int i = 0; i < 4; i++) cycle(0, 1, "R1 idle");

    // R2: start held with enable toggling
    for (int i = 0; i < 4; i++) cycle(1, i[0], "R2 start held");

    // R7/R3/R5: full run with continuous enable, values from arithmetic
    for (int n = 1; n <= 7; n++) begin
      cycle(0, 1, "R3 step");
      chk(prod == 13'(fact(n)), "R7 factorial", prod, fact(n));
      chk(idx == 3'(n), "R7 index", idx, n);
      chk(done == (n == 7), "R5 done timing", done, n == 7);
    end
    for (int i = 0; i < 5; i++) cycle(0, 1, "R5 done hold");

    // R6: restart after done, then sparse enable
    cycle(1, 0, "R6 restart");
    for (int i = 0; i < 30; i++) cycle(0, (i % 3) != 0, "R4 sparse enable");

    // R6: restart mid-sequence
    cycle(1, 1, "R6 restart");
    for (int i = 0; i < 3; i++) cycle(0, 1, "R3 step");
    cycle(1, 1, "R6 mid restart");
    for (int i = 0; i < 12; i++) cycle(0, i[1], "R4 hold pattern");

    // sweep of enable patterns, each from a fresh start
    for (int pat = 0; pat < 64; pat++) begin
      cycle(1, pat[0], "R2 start");
      for (int k = 0; k < 14; k++) cycle(0, pat[k % 6], "R3 sweep");
    end

    // R4: long stall then finish
    cycle(1, 0, "R6 restart");
    for (int i = 0; i < 5; i++) cycle(0, 0, "R4 stall");
    for (int i = 0; i < 9; i++) cycle(0, 1, "R5 finish");

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule